// File: doc/BRIEF.md
# Program/Erase Busy Status Responder

This block sits on the read path of a flash device model. While the device runs an internal program or erase, it replaces selected bits of the array data with two completion indicators. The first is a polling bit that reads as the inverse of what was last written. The second is a toggle bit that flips on every new read access. When the busy flag drops, the array data passes through unchanged. The busy flag and the operation timing come from elsewhere. The block only decides what byte goes on the bus.

A read access is open while both active-low selects, chip and output, are low. A new access starts when either select leaves and re-enters the active state. Software detects completion in one of two ways. It can check that the polling bit matches the data it wrote. Or it can read twice and check that the toggle bit did not change. The toggle bit's level when an operation starts or ends is not defined.

Top module: `flash_status_mux`

## Requirements
- R1: After reset, `busOut` is 0 and `driveEn` is 0.
- R2: While idle (`busy` = 0), a clock edge with an open access loads `busOut` with `arrayData`. `driveEn` is 1 in the cycle after such an edge.
- R3: While a program is busy (`busy` = 1, `eraseOp` = 0), bit 7 of `busOut` reads as the inverse of `loadedBit`. `loadedBit` is bit 7 of the last byte loaded for programming.
- R4: While an erase is busy (`busy` = 1, `eraseOp` = 1), bit 7 of `busOut` reads as 0.
- R5: While busy, bit 6 of `busOut` takes the opposite value on each successive read access.
- R6: Within a single open access, bit 6 holds its value from cycle to cycle.
- R7: While busy, bits 5 to 0 of `busOut` carry `arrayData`.
- R8: At the first clock edge of an open access that finds `busy` low, every bit of `busOut` carries `arrayData`, including bits 7 and 6. This applies even when busy drops in the middle of an access.
- R9: With no access open, `busOut` is 0 and `driveEn` is 0. Cycles without an access never advance the toggle bit.
- R10: A new access begun by cycling only `oeN` with `ceN` held low advances the toggle bit. So does one begun by cycling only `ceN` with `oeN` held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busy | input | 1 | An internal program or erase is in progress |
| eraseOp | input | 1 | 1 = the busy operation is an erase, 0 = a program |
| loadedBit | input | 1 | Bit 7 of the last byte loaded for programming |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| arrayData | input | 8 | Byte read from the array |
| busOut | output | 8 | Byte presented to the bus |
| driveEn | output | 1 | Bus output is being driven |

## Verification
The bench reads the toggle bit several times within one long access. A design that flips it every clock, instead of once per access, fails there. It also opens new accesses by cycling only one select at a time, which catches a design that watches just one of the two selects. It lets idle cycles pass between reads while busy, to catch a toggle that runs freely. It drops `busy` in the middle of an open access. A design that keeps status bits until the next access would show stale bits 7 and 6 at that point. Program and erase reads are compared bit 7 against bit 7, which exposes a swapped polarity or a missing erase case.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;    // an access is open this cycle
    logic toggleBit;  // toggle level to present at this edge
  } rdCtl_t;
endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   busy,
  input  logic   ceN,
  input  logic   oeN,
  output rdCtl_t ctl,
  output logic   driveEn
);
  logic accessNow;
  logic accessQ;
  logic readStart;
  logic toggleQ;

  assign accessNow = !ceN && !oeN;
  assign readStart = accessNow && !accessQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accessQ <= 1'b0;
      toggleQ <= 1'b0;
    end else begin
      accessQ <= accessNow;
      if (readStart && busy) toggleQ <= !toggleQ;
    end
  end

  always_comb begin
    ctl.capture   = accessNow;
    ctl.toggleBit = (readStart && busy) ? !toggleQ : toggleQ;
  end

  assign driveEn = accessQ;

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readStart && busy) |=> (toggleQ != $past(toggleQ)));

  // R9
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(readStart && busy) |=> $stable(toggleQ));

  // R2
  drive_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessNow |=> driveEn);
endmodule

// File: rtl/flash_status_dp.sv
module flash_status_dp
  import flash_status_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_POS = 7,
  parameter int TOG_POS  = 6
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              eraseOp,
  input  logic              loadedBit,
  input  logic [DATA_W-1:0] arrayData,
  input  rdCtl_t            ctl,
  output logic [DATA_W-1:0] busOut
);
  logic [DATA_W-1:0] nextByte;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    if (gi == POLL_POS) begin : g_poll
      assign nextByte[gi] = busy ? (eraseOp ? 1'b0 : !loadedBit) : arrayData[gi];
    end else if (gi == TOG_POS) begin : g_tog
      assign nextByte[gi] = busy ? ctl.toggleBit : arrayData[gi];
    end else begin : g_pass
      assign nextByte[gi] = arrayData[gi];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            busOut <= '0;
    else if (ctl.capture) busOut <= nextByte;
    else                  busOut <= '0;
  end

  // R8
  true_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !busy) |=> (busOut == $past(arrayData)));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> (busOut == '0));

  // R4
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && busy && eraseOp) |=> !busOut[POLL_POS]);

  // R3
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && busy && !eraseOp) |=> (busOut[POLL_POS] != $past(loadedBit)));
endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
  import flash_status_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_POS = 7,
  parameter int TOG_POS  = 6
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              eraseOp,
  input  logic              loadedBit,
  input  logic              ceN,
  input  logic              oeN,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] busOut,
  output logic              driveEn
);
  rdCtl_t ctl;

  flash_status_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busy(busy), .ceN(ceN), .oeN(oeN),
    .ctl(ctl), .driveEn(driveEn)
  );

  flash_status_dp #(.DATA_W(DATA_W), .POLL_POS(POLL_POS), .TOG_POS(TOG_POS)) dp_i (
    .clk(clk), .rstN(rstN), .busy(busy), .eraseOp(eraseOp),
    .loadedBit(loadedBit), .arrayData(arrayData), .ctl(ctl), .busOut(busOut)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (busOut == '0 && !driveEn));
endmodule

// File: tb/flash_status_mux_tb_top.sv
module flash_status_mux_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busy = 1'b0, eraseOp = 1'b0, loadedBit = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1;
  logic [7:0] arrayData = 8'h00;
  logic [7:0] busOut;
  logic driveEn;
  int checks = 0;
  int errors = 0;
  logic t1, t2;

  always #(CLK_PERIOD/2) clk = !clk;

  flash_status_mux dut_i (
    .clk(clk), .rstN(rstN), .busy(busy), .eraseOp(eraseOp), .loadedBit(loadedBit),
    .ceN(ceN), .oeN(oeN), .arrayData(arrayData), .busOut(busOut), .driveEn(driveEn)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic openRead();
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; tick();
  endtask

  task automatic closeRead();
    @(negedge clk); ceN = 1'b1; oeN = 1'b1; tick();
  endtask

  task automatic testReset();
    chk("R1 busOut", busOut, 8'h00);
    chk("R1 driveEn", {7'd0, driveEn}, 8'h00);
  endtask

  task automatic testIdleRead();
    busy = 1'b0; arrayData = 8'h5A;
    openRead();
    chk("R2 data", busOut, 8'h5A);
    chk("R2 driveEn", {7'd0, driveEn}, 8'h01);
    closeRead();
    chk("R9 busOut idle", busOut, 8'h00);
    chk("R9 driveEn idle", {7'd0, driveEn}, 8'h00);
  endtask

  task automatic testProgram();
    busy = 1'b1; eraseOp = 1'b0; loadedBit = 1'b1; arrayData = 8'h3C;
    openRead();
    chk("R3 poll bit", {7'd0, busOut[7]}, 8'h00);
    chk("R7 low bits", {2'b00, busOut[5:0]}, 8'h3C);
    t1 = busOut[6];
    tick(); tick();
    chk("R6 toggle within access", {7'd0, busOut[6]}, {7'd0, t1});
    closeRead();
    loadedBit = 1'b0;
    openRead();
    chk("R5 toggle flips", {7'd0, busOut[6]}, {7'd0, !t1});
    chk("R3 poll bit inverse", {7'd0, busOut[7]}, 8'h01);
    t2 = busOut[6];
    closeRead();
    openRead();
    chk("R5 toggle flips again", {7'd0, busOut[6]}, {7'd0, !t2});
    closeRead();
  endtask

  task automatic testErase();
    busy = 1'b1; eraseOp = 1'b1; arrayData = 8'hFF;
    openRead();
    chk("R4 erase poll", {7'd0, busOut[7]}, 8'h00);
    chk("R7 erase low bits", {2'b00, busOut[5:0]}, 8'h3F);
    closeRead();
  endtask

  task automatic testSingleSelect();
    busy = 1'b1; eraseOp = 1'b0;
    openRead();
    t1 = busOut[6];
    @(negedge clk); oeN = 1'b1; tick();
    @(negedge clk); oeN = 1'b0; tick();
    chk("R10 oe-only toggle", {7'd0, busOut[6]}, {7'd0, !t1});
    @(negedge clk); ceN = 1'b1; tick();
    @(negedge clk); ceN = 1'b0; tick();
    chk("R10 ce-only toggle", {7'd0, busOut[6]}, {7'd0, t1});
    closeRead();
  endtask

  task automatic testIdleGap();
    busy = 1'b1;
    openRead(); t1 = busOut[6]; closeRead();
    for (int i = 0; i < 5; i++) tick();
    openRead();
    chk("R9 idle no advance", {7'd0, busOut[6]}, {7'd0, !t1});
    closeRead();
  endtask

  task automatic testCompletion();
    busy = 1'b1; eraseOp = 1'b0; loadedBit = 1'b0; arrayData = 8'h47;
    openRead();
    chk("R3 busy status", {7'd0, busOut[7]}, 8'h01);
    @(negedge clk); busy = 1'b0; tick();
    chk("R8 true data mid access", busOut, 8'h47);
    arrayData = 8'hC3; tick();
    chk("R8 true data follows", busOut, 8'hC3);
    closeRead();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk); rstN = 1'b1;
    testIdleRead();
    testProgram();
    testErase();
    testSingleSelect();
    testIdleGap();
    testCompletion();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule